// File: doc/BRIEF.md
# Two-Wide Register Renamer

This block maps the 32 architectural integer registers onto 64 physical registers, for up to two instructions in each cycle. It keeps three pieces of state. The speculative map holds the current architectural-to-physical mapping. The committed map is the mapping as of the last retired instruction. The free pool is a bit per physical tag that marks which tags are unused. A rename lane that writes a register receives a fresh tag. It also receives the tag that the destination mapped to before, so that tag can be released when the instruction retires.

The rename results come out combinationally in the same cycle as the request. The state updates at the next rising clock edge, and only when `ren_ready_o` is high. The retire port writes the committed map and returns the replaced tags to the pool. A flush copies the committed map, including any retirements in the same cycle, into the speculative map. It also rebuilds the pool from every tag that the committed map does not hold.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, and the pool holds exactly tags 32..63. The first two allocations return 32 and then 33.
- R2: `ren_prs1_o`/`ren_prs2_o` of each lane return the speculative mapping of `ren_rs1_i`/`ren_rs2_i`. Register x0 always maps to tag 0.
- R3: A lane allocates when valid, write-enabled and rd≠0. It gets the lowest-numbered free tag, and lane 1 gets the lowest one left after lane 0. A lane that does not allocate, including one with rd=0, outputs 0 on `ren_prd_o` and `ren_lprd_o`. Tag 0 is never handed out.
- R4: `ren_lprd_o` of an allocating lane is the mapping its rd had before this rename.
- R5: When lane 0 allocates rd and lane 1 names the same register as a source or destination, lane 1 sees lane 0's new tag as its source and as its replaced mapping.
- R6: `ren_ready_o` is low when the pool holds fewer tags than the lanes request in that cycle. While it is low, no lane is renamed and neither map nor pool changes.
- R7: A valid, write-enabled retire with rd≠0 writes rd→`cmt_prd_i` into the committed map and returns `cmt_lprd_i` to the pool, where it can be allocated from the next cycle.
- R8: On `flush_i`, `ren_ready_o` is low. At the next edge, the speculative map takes the committed map including that cycle's retirements, and the pool becomes every tag the committed map does not reference.
- R9: When both retire lanes write the same rd in one cycle, lane 1 wins in the committed map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 2 | Rename request per lane |
| ren_wr_i | input | 2 | Lane writes a destination |
| ren_rd_i | input | 2x5 | Destination register per lane |
| ren_rs1_i | input | 2x5 | First source register per lane |
| ren_rs2_i | input | 2x5 | Second source register per lane |
| ren_ready_o | output | 1 | Requests accepted this cycle |
| ren_prs1_o | output | 2x6 | First source tag per lane |
| ren_prs2_o | output | 2x6 | Second source tag per lane |
| ren_prd_o | output | 2x6 | Newly allocated tag per lane |
| ren_lprd_o | output | 2x6 | Replaced tag per lane |
| cmt_valid_i | input | 2 | Retire per lane |
| cmt_wr_i | input | 2 | Retiring lane wrote a destination |
| cmt_rd_i | input | 2x5 | Retiring destination register |
| cmt_prd_i | input | 2x6 | Retiring destination tag |
| cmt_lprd_i | input | 2x6 | Tag to return to the pool |
| flush_i | input | 1 | Restore from committed state |

## Verification
Renaming is tried with independent pairs, pairs where lane 1 reads or rewrites lane 0's destination, a lone lane 1 request and an x0 destination. Together these separate the per-lane lookup, the intra-pair forwarding and the lowest-first tag order. The pool is drained until a two-tag request meets a single free tag. The mappings read back afterwards show that the refused pair left no trace. Retirements followed by allocations show that released tags come back first. Retirements paired with a flush, including two to one register, show that recovery uses the committed map and rebuilds the pool from it.

// File: rtl/reg_rename_pkg.sv
package reg_rename_pkg;
  localparam int unsigned ARCH_REGS = 32;
  localparam int unsigned PHYS_REGS = 64;
  localparam int unsigned LANES     = 2;
  localparam int unsigned AW        = $clog2(ARCH_REGS);
  localparam int unsigned PW        = $clog2(PHYS_REGS);
  localparam int unsigned CW        = $clog2(PHYS_REGS + 1);
  typedef logic [AW-1:0] areg_t;
  typedef logic [PW-1:0] preg_t;
endpackage

// File: rtl/rr_arch_map.sv
module rr_arch_map
  import reg_rename_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic  [LANES-1:0]       we_i,
  input  areg_t [LANES-1:0]       rd_i,
  input  preg_t [LANES-1:0]       prd_i,
  output preg_t [ARCH_REGS-1:0]   map_next_o
);
  preg_t [ARCH_REGS-1:0] map_q;

  // later lane overrides earlier on the same rd
  always_comb begin
    map_next_o = map_q;
    for (int l = 0; l < LANES; l++)
      if (we_i[l] && rd_i[l] != '0) map_next_o[rd_i[l]] = prd_i[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= preg_t'(i);
    end else begin
      map_q <= map_next_o;
    end
  end
endmodule

// File: rtl/rr_spec_map.sv
module rr_spec_map
  import reg_rename_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic  [LANES-1:0]       we_i,
  input  areg_t [LANES-1:0]       rd_i,
  input  preg_t [LANES-1:0]       prd_i,
  input  logic                    restore_i,
  input  preg_t [ARCH_REGS-1:0]   restore_map_i,
  output preg_t [ARCH_REGS-1:0]   map_o
);
  preg_t [ARCH_REGS-1:0] map_q, map_d;

  always_comb begin
    map_d = map_q;
    if (restore_i) begin
      map_d = restore_map_i;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (we_i[l]) map_d[rd_i[l]] = prd_i[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= preg_t'(i);
    end else begin
      map_q <= map_d;
    end
  end

  assign map_o = map_q;
endmodule

// File: rtl/rr_free_list.sv
module rr_free_list
  import reg_rename_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic  [LANES-1:0]       req_i,
  input  logic                    fire_i,
  input  logic  [LANES-1:0]       rel_i,
  input  preg_t [LANES-1:0]       rel_tag_i,
  input  logic                    rebuild_i,
  input  preg_t [ARCH_REGS-1:0]   ref_map_i,
  output preg_t [LANES-1:0]       tag_o,
  output logic                    ready_o
);
  logic [PHYS_REGS-1:0] free_q, free_d, avail, taken, rel_mask, ref_mask;
  logic [CW-1:0]        need, have;

  // lowest-first pick, each lane sees the pool minus earlier picks
  always_comb begin
    preg_t pick;
    avail = free_q;
    taken = '0;
    for (int l = 0; l < LANES; l++) begin
      pick = '0;
      for (int p = PHYS_REGS - 1; p >= 0; p--)
        if (avail[p]) pick = preg_t'(p);
      tag_o[l] = pick;
      if (req_i[l]) begin
        avail[pick] = 1'b0;
        taken[pick] = 1'b1;
      end
    end
  end

  assign need    = CW'($countones(req_i));
  assign have    = CW'($countones(free_q));
  assign ready_o = (have >= need);

  always_comb begin
    rel_mask = '0;
    ref_mask = '0;
    for (int l = 0; l < LANES; l++)
      if (rel_i[l]) rel_mask[rel_tag_i[l]] = 1'b1;
    for (int a = 0; a < ARCH_REGS; a++)
      ref_mask[ref_map_i[a]] = 1'b1;
    if (rebuild_i) free_d = ~ref_mask;
    else           free_d = (fire_i ? (free_q & ~taken) : free_q) | rel_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PHYS_REGS; p++) free_q[p] <= (p >= ARCH_REGS);
    end else begin
      free_q <= free_d;
    end
  end
endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import reg_rename_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0]            ren_valid_i,
  input  logic [LANES-1:0]            ren_wr_i,
  input  logic [LANES-1:0][AW-1:0]    ren_rd_i,
  input  logic [LANES-1:0][AW-1:0]    ren_rs1_i,
  input  logic [LANES-1:0][AW-1:0]    ren_rs2_i,
  output logic                        ren_ready_o,
  output logic [LANES-1:0][PW-1:0]    ren_prs1_o,
  output logic [LANES-1:0][PW-1:0]    ren_prs2_o,
  output logic [LANES-1:0][PW-1:0]    ren_prd_o,
  output logic [LANES-1:0][PW-1:0]    ren_lprd_o,
  input  logic [LANES-1:0]            cmt_valid_i,
  input  logic [LANES-1:0]            cmt_wr_i,
  input  logic [LANES-1:0][AW-1:0]    cmt_rd_i,
  input  logic [LANES-1:0][PW-1:0]    cmt_prd_i,
  input  logic [LANES-1:0][PW-1:0]    cmt_lprd_i,
  input  logic                        flush_i
);
  logic  [LANES-1:0]     alloc, cmt_we, rel;
  logic                  fl_ready, fire;
  preg_t [LANES-1:0]     fl_tag;
  preg_t [ARCH_REGS-1:0] spec_map, arch_next;

  for (genvar l = 0; l < LANES; l++) begin : g_ctl
    assign alloc[l]  = ren_valid_i[l] & ren_wr_i[l] & (ren_rd_i[l] != '0);
    assign cmt_we[l] = cmt_valid_i[l] & cmt_wr_i[l];
    assign rel[l]    = cmt_we[l] & (cmt_rd_i[l] != '0);
  end

  assign ren_ready_o = fl_ready & ~flush_i;
  assign fire        = ren_ready_o;

  rr_free_list u_free (
    .clk_i, .rst_ni,
    .req_i     (alloc),
    .fire_i    (fire),
    .rel_i     (rel),
    .rel_tag_i (cmt_lprd_i),
    .rebuild_i (flush_i),
    .ref_map_i (arch_next),
    .tag_o     (fl_tag),
    .ready_o   (fl_ready)
  );

  rr_spec_map u_spec (
    .clk_i, .rst_ni,
    .we_i          (alloc & {LANES{fire}}),
    .rd_i          (ren_rd_i),
    .prd_i         (fl_tag),
    .restore_i     (flush_i),
    .restore_map_i (arch_next),
    .map_o         (spec_map)
  );

  rr_arch_map u_arch (
    .clk_i, .rst_ni,
    .we_i       (cmt_we),
    .rd_i       (cmt_rd_i),
    .prd_i      (cmt_prd_i),
    .map_next_o (arch_next)
  );

  // per-lane lookup with forwarding from older lanes of the same group
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    preg_t s1, s2, old;
    always_comb begin
      s1  = spec_map[ren_rs1_i[l]];
      s2  = spec_map[ren_rs2_i[l]];
      old = spec_map[ren_rd_i[l]];
      for (int k = 0; k < l; k++) begin
        if (alloc[k]) begin
          if (ren_rd_i[k] == ren_rs1_i[l]) s1  = fl_tag[k];
          if (ren_rd_i[k] == ren_rs2_i[l]) s2  = fl_tag[k];
          if (ren_rd_i[k] == ren_rd_i[l])  old = fl_tag[k];
        end
      end
    end
    assign ren_prs1_o[l] = s1;
    assign ren_prs2_o[l] = s2;
    assign ren_prd_o[l]  = alloc[l] ? fl_tag[l] : '0;
    assign ren_lprd_o[l] = alloc[l] ? old : '0;
  end
endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk
  import reg_rename_pkg::*;
(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [LANES-1:0]            ren_valid_i,
  input logic [LANES-1:0]            ren_wr_i,
  input logic [LANES-1:0][AW-1:0]    ren_rd_i,
  input logic [LANES-1:0][AW-1:0]    ren_rs1_i,
  input logic [LANES-1:0][AW-1:0]    ren_rs2_i,
  input logic                        ren_ready_o,
  input logic [LANES-1:0][PW-1:0]    ren_prs1_o,
  input logic [LANES-1:0][PW-1:0]    ren_prs2_o,
  input logic [LANES-1:0][PW-1:0]    ren_prd_o,
  input logic [LANES-1:0][PW-1:0]    ren_lprd_o,
  input logic [LANES-1:0]            cmt_valid_i,
  input logic [LANES-1:0]            cmt_wr_i,
  input logic [LANES-1:0][AW-1:0]    cmt_rd_i,
  input logic [LANES-1:0][PW-1:0]    cmt_prd_i,
  input logic [LANES-1:0][PW-1:0]    cmt_lprd_i,
  input logic                        flush_i
);
  logic a0, a1;
  assign a0 = ren_valid_i[0] & ren_wr_i[0] & (ren_rd_i[0] != '0);
  assign a1 = ren_valid_i[1] & ren_wr_i[1] & (ren_rd_i[1] != '0);

  // R3
  distinct_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_ready_o && a0 && a1) |-> (ren_prd_o[0] != ren_prd_o[1]));

  // R3
  no_zero_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_ready_o && a0) |-> (ren_prd_o[0] != '0));

  // R2
  zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_rs1_i[0] == '0) |-> (ren_prs1_o[0] == '0));

  // R5
  pair_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a0 && ren_rs2_i[1] == ren_rd_i[0]) |-> (ren_prs2_o[1] == ren_prd_o[0]));

  // R5
  pair_lprd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a0 && a1 && ren_rd_i[1] == ren_rd_i[0]) |-> (ren_lprd_o[1] == ren_prd_o[0]));

  // R8
  flush_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !ren_ready_o);
endmodule

bind reg_rename reg_rename_chk u_chk (.*);

// File: tb/reg_rename_test.sv
module reg_rename_test;
  import reg_rename_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                     rst_ni;
  logic [LANES-1:0]         ren_valid, ren_wr, cmt_valid, cmt_wr;
  logic [LANES-1:0][AW-1:0] ren_rd, ren_rs1, ren_rs2, cmt_rd;
  logic [LANES-1:0][PW-1:0] prs1, prs2, prd, lprd, cmt_prd, cmt_lprd;
  logic                     ren_ready, flush;

  reg_rename uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ren_valid_i(ren_valid), .ren_wr_i(ren_wr), .ren_rd_i(ren_rd),
    .ren_rs1_i(ren_rs1), .ren_rs2_i(ren_rs2), .ren_ready_o(ren_ready),
    .ren_prs1_o(prs1), .ren_prs2_o(prs2), .ren_prd_o(prd), .ren_lprd_o(lprd),
    .cmt_valid_i(cmt_valid), .cmt_wr_i(cmt_wr), .cmt_rd_i(cmt_rd),
    .cmt_prd_i(cmt_prd), .cmt_lprd_i(cmt_lprd), .flush_i(flush)
  );

  typedef struct {
    string tag;
    int    rdy;
    int    s1[LANES];
    int    s2[LANES];
    int    d[LANES];
    int    l[LANES];
  } exp_t;

  exp_t q[$];
  event mon_ev;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;
  int   m_spec[ARCH_REGS], m_arch[ARCH_REGS];
  bit   m_free[PHYS_REGS];

  function automatic void chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endfunction

  // monitor: pops the expected item and compares the outputs
  always @(mon_ev) begin
    exp_t e;
    e = q.pop_front();
    chk(e.tag, "ready", int'(ren_ready), e.rdy);
    for (int l = 0; l < LANES; l++) begin
      chk(e.tag, $sformatf("prs1[%0d]", l), int'(prs1[l]), e.s1[l]);
      chk(e.tag, $sformatf("prs2[%0d]", l), int'(prs2[l]), e.s2[l]);
      chk(e.tag, $sformatf("prd[%0d]", l),  int'(prd[l]),  e.d[l]);
      chk(e.tag, $sformatf("lprd[%0d]", l), int'(lprd[l]), e.l[l]);
    end
  end

  task automatic clear_in();
    ren_valid = '0; ren_wr = '0; ren_rd = '0; ren_rs1 = '0; ren_rs2 = '0;
    cmt_valid = '0; cmt_wr = '0; cmt_rd = '0; cmt_prd = '0; cmt_lprd = '0;
    flush = 1'b0;
  endtask

  task automatic ren(int l, bit w, int rd, int a, int b);
    ren_valid[l] = 1'b1; ren_wr[l] = w;
    ren_rd[l] = AW'(rd); ren_rs1[l] = AW'(a); ren_rs2[l] = AW'(b);
  endtask

  task automatic cmt(int l, int rd, int p, int lp);
    cmt_valid[l] = 1'b1; cmt_wr[l] = 1'b1;
    cmt_rd[l] = AW'(rd); cmt_prd[l] = PW'(p); cmt_lprd[l] = PW'(lp);
  endtask

  // driver: builds the expected item from the reference state, then advances it
  task automatic step(string tag);
    exp_t e;
    int   cnt, need, s1, s2, old;
    bit   av[PHYS_REGS];
    bit   al[LANES];
    int   tg[LANES];
    @(negedge clk);
    e.tag = tag;
    cnt = 0; need = 0;
    for (int p = 0; p < PHYS_REGS; p++) cnt += int'(m_free[p]);
    for (int l = 0; l < LANES; l++) begin
      al[l] = ren_valid[l] && ren_wr[l] && ren_rd[l] != 0;
      need += int'(al[l]);
    end
    e.rdy = (!flush && cnt >= need) ? 1 : 0;
    av = m_free;
    for (int l = 0; l < LANES; l++) begin
      tg[l] = 0;
      for (int p = 0; p < PHYS_REGS; p++) if (av[p]) begin tg[l] = p; break; end
      if (al[l]) av[tg[l]] = 1'b0;
      s1 = m_spec[ren_rs1[l]]; s2 = m_spec[ren_rs2[l]]; old = m_spec[ren_rd[l]];
      for (int k = 0; k < l; k++) if (al[k]) begin
        if (ren_rd[k] == ren_rs1[l]) s1 = tg[k];
        if (ren_rd[k] == ren_rs2[l]) s2 = tg[k];
        if (ren_rd[k] == ren_rd[l])  old = tg[k];
      end
      e.s1[l] = s1; e.s2[l] = s2;
      e.d[l] = al[l] ? tg[l] : 0;
      e.l[l] = al[l] ? old : 0;
    end
    q.push_back(e);
    -> mon_ev;
    @(posedge clk);
    if (e.rdy == 1)
      for (int l = 0; l < LANES; l++) if (al[l]) begin
        m_spec[ren_rd[l]] = tg[l]; m_free[tg[l]] = 1'b0;
      end
    for (int l = 0; l < LANES; l++)
      if (cmt_valid[l] && cmt_wr[l] && cmt_rd[l] != 0) begin
        m_arch[cmt_rd[l]] = int'(cmt_prd[l]); m_free[cmt_lprd[l]] = 1'b1;
      end
    if (flush) begin
      for (int p = 0; p < PHYS_REGS; p++) m_free[p] = 1'b1;
      for (int a = 0; a < ARCH_REGS; a++) begin
        m_spec[a] = m_arch[a]; m_free[m_arch[a]] = 1'b0;
      end
    end
    #1;
    clear_in();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int a = 0; a < ARCH_REGS; a++) begin m_spec[a] = a; m_arch[a] = a; end
    for (int p = 0; p < PHYS_REGS; p++) m_free[p] = (p >= ARCH_REGS);
    clear_in();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1: identity map, first tags 32 and 33; lane 1 reads x1 (R5 forwarding)
    ren(0, 1, 1, 5, 31); ren(1, 1, 2, 0, 1); step("R1");
    // R2: plain lookups, x0 source
    ren(0, 0, 0, 1, 2); ren(1, 0, 0, 0, 3); step("R2");
    // R3: x0 destination allocates nothing, lone lane 1 takes the lowest tag
    ren(0, 1, 0, 4, 0); ren(1, 1, 9, 9, 0); step("R3");
    // R4: rewriting x1 reports its previous tag
    ren(0, 1, 1, 1, 0); step("R4");
    // R5: both lanes on x7
    ren(0, 1, 7, 1, 0); ren(1, 1, 7, 7, 7); step("R5");
    // R6: drain the pool down to one tag
    for (int i = 0; i < 12; i++) begin
      ren(0, 1, 8 + i, 0, 0); ren(1, 1, 31 - i, 8 + i, 0); step("R6");
    end
    ren(0, 1, 5, 5, 0); step("R6");
    ren(0, 1, 6, 6, 0); ren(1, 1, 3, 5, 6); step("R6");
    ren(0, 0, 0, 6, 3); ren(1, 0, 0, 5, 7); step("R6");
    ren(0, 1, 6, 6, 0); step("R6");
    ren(0, 1, 4, 4, 0); step("R6");
    // R7: retire first two renames, released tags come back lowest first
    cmt(0, 1, 32, 1); cmt(1, 2, 33, 2); step("R7");
    ren(0, 1, 10, 1, 2); ren(1, 1, 11, 10, 0); step("R7");
    // R9: two retirements to x3
    cmt(0, 3, 40, 3); cmt(1, 3, 41, 40); step("R9");
    // R8: flush with a same-cycle retirement and a rename request
    cmt(0, 4, 50, 4); flush = 1'b1; ren(0, 1, 12, 1, 2); step("R8");
    ren(0, 0, 0, 3, 7); step("R9");
    ren(0, 0, 0, 4, 1); ren(1, 0, 0, 2, 10); step("R8");
    ren(0, 1, 13, 4, 0); ren(1, 1, 14, 13, 3); step("R8");

    finish_run();
  end
endmodule